// File: doc/BRIEF.md
# Presettable Up Counter with Terminal-Count Reload

This block is a synchronous binary up counter, eight bits wide by default, that runs on the rising edge of a single clock. A parallel preset word can be loaded on any edge through an active-low load control. An active-low enable lets the count advance, and with the enable high the value holds. An active-high master reset acts at once, without waiting for a clock edge. It clears the count and releases the flag.

An active-low terminal-count flag is low while every count bit is one. A reload-select input sets what the counter does after that state. With the input low, which is the value to tie it to when unused, the counter wraps to zero. With the input high, the next counting edge loads the preset again. The counter then divides the clock by 2^W minus the preset, and the flag gives one single-cycle low pulse per period.

Top module: `preset_upcounter`

## Requirements
- R1: While `arst_i` is high, `count_o` is 0 and `term_n_o` is 1. Both take these values as soon as reset rises, without a clock edge.
- R2: On a rising edge with `load_n_i` = 0, `count_o` takes the value of `preset_i`. This holds whatever the values of `cnt_en_n_i`, `tc_reload_i` and the present count.
- R3: On a rising edge with `load_n_i` = 1 and `cnt_en_n_i` = 0, the count rises by one, unless the count is all ones and `tc_reload_i` = 1.
- R4: On a rising edge with `load_n_i` = 1 and `cnt_en_n_i` = 1, `count_o` keeps its value. This includes the all-ones state with `tc_reload_i` = 1.
- R5: `term_n_o` is 0 exactly when every bit of `count_o` is 1, whatever the value of `cnt_en_n_i`. It changes only after a clock edge or a reset.
- R6: With `tc_reload_i` = 0, counting from all ones gives 0 on the next enabled edge.
- R7: With `tc_reload_i` = 1, counting from all ones loads `preset_i` on the next enabled edge.
- R8: With `tc_reload_i` = 1 and counting enabled, `term_n_o` pulses low for one cycle every 2^W − P cycles, where P is the preset value. For example, P = 0x8F gives a period of 113 cycles, and P = 0xFF keeps the count at all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the counter acts on the rising edge |
| arst_i | input | 1 | Asynchronous master reset, active high |
| preset_i | input | W | Parallel preset value |
| load_n_i | input | 1 | Parallel load control, active low |
| cnt_en_n_i | input | 1 | Count enable, active low |
| tc_reload_i | input | 1 | Reload select: 1 reloads the preset after all ones, 0 wraps to zero |
| count_o | output | W | Present count |
| term_n_o | output | 1 | Terminal-count flag, active low, low while the count is all ones |

## Verification
The clocked properties assume that every control input and `preset_i` stay steady around the rising edge. They also assume that reset is never released in the same time step as a clock edge. The bench changes every input on the falling edge. It raises and drops reset a quarter period away from any edge. The bench compares the outputs with the reference model on each falling edge, half a cycle after the outputs have settled.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } ucnt_op_e;
endpackage

// File: rtl/ucnt_ctrl.sv
module ucnt_ctrl
  import ucnt_pkg::*;
(
  input  logic     load_n,
  input  logic     cnt_en_n,
  input  logic     tc_reload,
  input  logic     term_n,
  output ucnt_op_e op,
  output logic     reload_evt,
  output logic     wrap_evt
);
  logic counting;

  // Counting happens only when load is off and enable is on.
  assign counting   = load_n && !cnt_en_n;
  assign reload_evt = counting && !term_n && tc_reload;
  assign wrap_evt   = counting && !term_n && !tc_reload;

  // Priority: explicit load, then hold, then reload on terminal count, then increment.
  always_comb begin
    if (!load_n)         op = OP_LOAD;
    else if (cnt_en_n)   op = OP_HOLD;
    else if (reload_evt) op = OP_LOAD;
    else                 op = OP_INC;
  end
endmodule

// File: rtl/ucnt_reg.sv
module ucnt_reg
  import ucnt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         arst,
  input  ucnt_op_e     op,
  input  logic [W-1:0] preset,
  output logic [W-1:0] count_q
);
  function automatic logic [W-1:0] next_value(ucnt_op_e o, logic [W-1:0] cur,
                                               logic [W-1:0] pre);
    case (o)
      OP_LOAD: return pre;
      OP_INC:  return cur + {{(W-1){1'b0}}, 1'b1};
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or posedge arst) begin
    if (arst) count_q <= '0;
    else      count_q <= next_value(op, count_q, preset);
  end
endmodule

// File: rtl/ucnt_tc.sv
module ucnt_tc #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] count,
  output logic         term_n
);
  function automatic logic all_ones(logic [W-1:0] v);
    return &v;
  endfunction

  assign term_n = !all_ones(count);
endmodule

// File: rtl/preset_upcounter.sv
module preset_upcounter
  import ucnt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         arst_i,
  input  logic [W-1:0] preset_i,
  input  logic         load_n_i,
  input  logic         cnt_en_n_i,
  input  logic         tc_reload_i,
  output logic [W-1:0] count_o,
  output logic         term_n_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  ucnt_op_e     op;
  logic         reload_evt;
  logic         wrap_evt;
  logic [W-1:0] count_q;
  logic         term_n;

  ucnt_ctrl u_ctrl (
    .load_n     (load_n_i),
    .cnt_en_n   (cnt_en_n_i),
    .tc_reload  (tc_reload_i),
    .term_n     (term_n),
    .op         (op),
    .reload_evt (reload_evt),
    .wrap_evt   (wrap_evt)
  );

  ucnt_reg #(.W(W)) u_reg (
    .clk     (clk_i),
    .arst    (arst_i),
    .op      (op),
    .preset  (preset_i),
    .count_q (count_q)
  );

  ucnt_tc #(.W(W)) u_tc (
    .count  (count_q),
    .term_n (term_n)
  );

  assign count_o  = count_q;
  assign term_n_o = term_n;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    arst_i |-> (count_o == '0 && term_n_o));

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    !load_n_i |=> count_o == $past(preset_i));

  // R3
  inc_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    (load_n_i && !cnt_en_n_i && term_n_o) |=> count_o == $past(count_o) + 1'b1);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    (load_n_i && cnt_en_n_i) |=> $stable(count_o));

  // R5
  term_flag_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    (count_o == ALL_ONES) |-> !term_n_o);

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    wrap_evt |=> count_o == '0);

  // R7
  reload_chk: assert property (@(posedge clk_i) disable iff (arst_i)
    reload_evt |=> count_o == $past(preset_i));
endmodule

// File: tb/test_preset_upcounter.sv
module test_preset_upcounter;
  localparam int W = 8;
  localparam int CLK = 10;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 0;
  logic         arst = 1;
  logic [W-1:0] preset = '0;
  logic         load_n = 1, cen_n = 1, rel = 0;
  logic [W-1:0] count;
  logic         term_n;

  int model = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  preset_upcounter #(.W(W)) i_preset_upcounter (
    .clk_i(clk), .arst_i(arst), .preset_i(preset), .load_n_i(load_n),
    .cnt_en_n_i(cen_n), .tc_reload_i(rel), .count_o(count), .term_n_o(term_n));

  always #(CLK/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    check({req, " count"}, int'(count), model);
    check({req, " term_n"}, int'(term_n), (model == MAXV) ? 0 : 1);
  endtask

  // One cycle: drive on the falling edge, update the model at the rising edge, compare on the next falling edge.
  task automatic cyc(bit ld, bit ce, bit rl, int pre, string req);
    load_n = ld; cen_n = ce; rel = rl; preset = pre[W-1:0];
    @(posedge clk);
    if (!ld) model = pre;
    else if (!ce) begin
      if (model == MAXV && rl) model = pre;
      else model = (model + 1) % (MAXV + 1);
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(CLK * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int last, gap;
    @(negedge clk);
    compare("R1 reset");
    @(negedge clk);
    #(CLK/4) arst = 0;
    @(negedge clk);
    compare("R1 after release");

    cyc(0, 1, 0, 8'hFC, "R2 load with enable off");
    cyc(1, 1, 0, 8'h00, "R4 hold");
    cyc(1, 1, 1, 8'h00, "R4 hold");
    cyc(1, 0, 0, 8'h00, "R3 inc");
    cyc(1, 0, 0, 8'h00, "R3 inc");
    cyc(1, 0, 0, 8'h00, "R5 all ones");
    cyc(1, 0, 0, 8'h33, "R6 wrap");
    cyc(1, 0, 0, 8'h00, "R3 inc");

    cyc(0, 1, 1, 8'hFF, "R2 load all ones");
    cyc(1, 1, 1, 8'h12, "R4 hold at all ones with reload");
    cyc(1, 1, 0, 8'h12, "R5 flag while holding");
    cyc(0, 0, 1, 8'h10, "R2 load beats reload");
    cyc(0, 0, 0, 8'hFE, "R2 load with enable on");
    cyc(1, 0, 1, 8'h40, "R3 inc");
    cyc(1, 0, 1, 8'h40, "R7 reload");
    cyc(1, 0, 1, 8'h40, "R3 inc after reload");

    cyc(0, 0, 1, 8'h8F, "R2 load divider preset");
    last = -1;
    for (int i = 0; i < 300; i++) begin
      cyc(1, 0, 1, 8'h8F, "R8 divide run");
      if (!term_n) begin
        if (last >= 0) begin
          gap = i - last;
          check("R8 period", gap, 113);
        end
        last = i;
      end
    end

    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 8'h00, "R3 inc");
    #(CLK/4) arst = 1;
    #1;
    model = 0;
    compare("R1 async reset");
    @(negedge clk);
    compare("R1 held");
    #(CLK/4) arst = 0;
    @(negedge clk);

    cyc(0, 0, 1, 8'hFF, "R2 load FF");
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 8'hFF, "R8 modulus one");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule